// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog that makes the system reset line fire if software stops servicing it. It counts up on a 64-bit counter against a 64-bit period. Software arms it through a control word. The enable bit is bit 14 and the key is bits 31:16. Arming takes two key values, written in a fixed order.

After arming, the counter runs every clock. Software keeps the system alive by writing the same two keys again, which returns the count to zero. Two events fire the reset output for a fixed number of clocks: the count reaching the period, or any foreign key while armed. Clock selection and prescaling are not part of the block. The general-purpose timer modes are not part of it either.

Software reaches the block through a simple word-addressed register bus. A write takes one clock. Read data is registered, so it appears one clock after the address.

Top module: `wdt_keyed`

## Requirements
- R1: A synchronous reset clears everything. This covers the mode, counter, period and enable registers and the service flag. It leaves the guard state idle (code 0) and `sys_rst_o` low.
- R2: The register map uses word addresses. 0 is the mode register, with mode in bits 1:0. 1 and 2 are the counter low and high words. 3 and 4 are the period low and high words. 5 is the control register. A control read returns the state code (idle 0, pre-active 1, active 2) in bits 1:0, the service flag in bit 13 and the enable bit in bit 14. Read data shows the addressed register one clock after the address. Any other address reads zero.
- R3: Control writes have no effect unless the mode field is 2'b10 (watchdog mode). Once enable is set, writes to the mode register are ignored.
- R4: A control write with bit 14 set sets enable. Enable can then be cleared only by reset, whatever later writes carry in bit 14.
- R5: In idle, key 0xA5C6 moves the unit to pre-active. This happens only if enable is already set or is set by that same write.
- R6: In pre-active, key 0xDA7E moves the unit to active. The counter increases by one every clock only while the unit is active.
- R7: Outside active, any key other than the one that advances the state leaves the state unchanged.
- R8: In active, key 0xA5C6 sets the service flag. A following 0xDA7E clears the flag and restarts the counter from zero. A 0xDA7E written without the flag set has no effect.
- R9: In active, a control write whose key is neither 0xA5C6 nor 0xDA7E fires the reset. `sys_rst_o` goes high on the clock edge that takes the write.
- R10: In active, when the count equals the period, the reset fires on the next clock edge.
- R11: A firing holds `sys_rst_o` high for PULSE_W clocks. It also returns the state to idle, clears the counter and the service flag, and keeps enable set.
- R12: While active, writes to the counter and period registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous clock |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The assertions assume that reset is held for at least one clock before traffic starts. They also assume the bus is only ever write-strobed with a defined address. The active-state checks rely on the mode register being locked, which means they assume no other path can change it. The stimulus drives inputs only on falling edges, keeps the strobe to one clock per write, and leaves the address parked on a readable register between writes. Service gaps are kept shorter than the programmed period, except in the one phase meant to time out.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_PRE  = 2'd1,
    WD_ACT  = 2'd2
  } wd_state_e;

  localparam logic [15:0] KEY_ARM = 16'hA5C6;
  localparam logic [15:0] KEY_GO  = 16'hDA7E;
  localparam int          EN_BIT  = 14;
  localparam int          SVC_BIT = 13;
  localparam int          KEY_LSB = 16;
  localparam logic [1:0]  MODE_WDOG = 2'b10;

  localparam int ADR_MODE   = 0;
  localparam int ADR_CNT_LO = 1;
  localparam int ADR_CNT_HI = 2;
  localparam int ADR_PRD_LO = 3;
  localparam int ADR_PRD_HI = 4;
  localparam int ADR_CTL    = 5;
endpackage

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wd_mode_i,
  input  logic        ctl_we_i,
  input  logic [15:0] key_i,
  input  logic        en_bit_i,
  input  logic        at_limit_i,
  output wd_state_e   state_o,
  output logic        en_o,
  output logic        svc_o,
  output logic        restart_o,
  output logic        fire_o
);
  wd_state_e state_q;
  logic      en_q, svc_q;
  logic      wr, is_arm, is_go, active, en_next;

  always_comb begin
    wr        = ctl_we_i && wd_mode_i;
    is_arm    = (key_i == KEY_ARM);
    is_go     = (key_i == KEY_GO);
    active    = (state_q == WD_ACT);
    en_next   = en_q | (wr & en_bit_i);
    fire_o    = active && (at_limit_i || (wr && !is_arm && !is_go));
    restart_o = active && wr && is_go && svc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WD_IDLE;
      en_q    <= 1'b0;
      svc_q   <= 1'b0;
    end else begin
      en_q <= en_next;
      if (fire_o) begin
        state_q <= WD_IDLE;
        svc_q   <= 1'b0;
      end else if (wr) begin
        unique case (state_q)
          WD_IDLE: if (is_arm && en_next) state_q <= WD_PRE;
          WD_PRE:  if (is_go) begin
                     state_q <= WD_ACT;
                     svc_q   <= 1'b0;
                   end
          WD_ACT:  if (is_arm) svc_q <= 1'b1;
                   else if (is_go) svc_q <= 1'b0;
          default: state_q <= WD_IDLE;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign en_o    = en_q;
  assign svc_o   = svc_q;

  assert_en_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    $past(en_q) |-> en_q);
  assert_act_from_pre_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_ACT) |-> ($past(state_q) == WD_ACT || $past(state_q) == WD_PRE));
  assert_pre_holds_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == WD_PRE) |-> (state_q != WD_IDLE));
  assert_svc_only_active_R8: assert property (@(posedge clk) disable iff (rst)
    svc_q |-> (state_q == WD_ACT));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             fire_i,
  input  logic             restart_i,
  input  logic             cnt_lo_we_i,
  input  logic             cnt_hi_we_i,
  input  logic             prd_lo_we_i,
  input  logic             prd_hi_we_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] prd_o,
  output logic             at_limit_o
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q, prd_q;
  logic             any_we;

  assign any_we = cnt_lo_we_i | cnt_hi_we_i | prd_lo_we_i | prd_hi_we_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      prd_q <= '0;
    end else if (fire_i || restart_i) begin
      cnt_q <= '0;
    end else if (active_i) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      if (cnt_lo_we_i) cnt_q[31:0]       <= wdata_i;
      if (cnt_hi_we_i) cnt_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
      if (prd_lo_we_i) prd_q[31:0]       <= wdata_i;
      if (prd_hi_we_i) prd_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
    end
  end

  assign cnt_o      = cnt_q;
  assign prd_o      = prd_q;
  assign at_limit_o = (cnt_q == prd_q);

  assert_prd_locked_R12: assert property (@(posedge clk) disable iff (rst)
    $past(active_i) |-> $stable(prd_q));
  assert_cnt_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(active_i) && !$past(any_we)) |-> $stable(cnt_q));
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(active_i) && !$past(fire_i) && !$past(restart_i))
      |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic rst_o
);
  localparam int LW = $clog2(PULSE_W + 1);

  logic [LW-1:0] left_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      left_q <= '0;
    end else if (fire_i) begin
      out_q  <= 1'b1;
      left_q <= LW'(PULSE_W - 1);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      out_q <= 1'b0;
    end
  end

  assign rst_o = out_q;

  assert_rise_needs_fire_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> $past(fire_i));
  assert_fire_drives_R11: assert property (@(posedge clk) disable iff (rst)
    fire_i |=> out_q);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int CNT_W   = 64,
  parameter int PULSE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_o
);
  logic [1:0]       mode_q;
  logic [31:0]      rdata_q;
  wd_state_e        state;
  logic             en, svc, restart, fire, at_limit, active;
  logic [CNT_W-1:0] cnt, prd;
  logic             sel_mode, sel_clo, sel_chi, sel_plo, sel_phi, sel_ctl;

  always_comb begin
    sel_mode = (bus_addr == ADDR_W'(ADR_MODE));
    sel_clo  = (bus_addr == ADDR_W'(ADR_CNT_LO));
    sel_chi  = (bus_addr == ADDR_W'(ADR_CNT_HI));
    sel_plo  = (bus_addr == ADDR_W'(ADR_PRD_LO));
    sel_phi  = (bus_addr == ADDR_W'(ADR_PRD_HI));
    sel_ctl  = (bus_addr == ADDR_W'(ADR_CTL));
    active   = (state == WD_ACT);
  end

  always_ff @(posedge clk) begin
    if (rst)                            mode_q <= '0;
    else if (bus_we && sel_mode && !en) mode_q <= bus_wdata[1:0];
  end

  wdt_key_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wd_mode_i (mode_q == MODE_WDOG),
    .ctl_we_i  (bus_we && sel_ctl),
    .key_i     (bus_wdata[31:KEY_LSB]),
    .en_bit_i  (bus_wdata[EN_BIT]),
    .at_limit_i(at_limit),
    .state_o   (state),
    .en_o      (en),
    .svc_o     (svc),
    .restart_o (restart),
    .fire_o    (fire)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .active_i   (active),
    .fire_i     (fire),
    .restart_i  (restart),
    .cnt_lo_we_i(bus_we && sel_clo),
    .cnt_hi_we_i(bus_we && sel_chi),
    .prd_lo_we_i(bus_we && sel_plo),
    .prd_hi_we_i(bus_we && sel_phi),
    .wdata_i    (bus_wdata),
    .cnt_o      (cnt),
    .prd_o      (prd),
    .at_limit_o (at_limit)
  );

  wdt_rst_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .fire_i(fire),
    .rst_o (sys_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (sel_mode) rdata_q <= {30'b0, mode_q};
      if (sel_clo)  rdata_q <= cnt[31:0];
      if (sel_chi)  rdata_q <= 32'(cnt >> 32);
      if (sel_plo)  rdata_q <= prd[31:0];
      if (sel_phi)  rdata_q <= 32'(prd >> 32);
      if (sel_ctl)  rdata_q <= {16'h0, 1'b0, en, svc, 11'b0, state};
    end
  end

  assign bus_rdata = rdata_q;

  assert_mode_locked_R3: assert property (@(posedge clk) disable iff (rst)
    $past(en) |-> $stable(mode_q));
  assert_bad_key_fires_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel_ctl && active && bus_wdata[31:16] != KEY_ARM
       && bus_wdata[31:16] != KEY_GO) |=> sys_rst_o);
  assert_timeout_fires_R10: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == prd) |=> (sys_rst_o && state == WD_IDLE));
endmodule

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/1ps
module wdt_keyed_bench;
  localparam int PW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        sys_rst_o;

  always #10 clk = ~clk;

  wdt_keyed #(.ADDR_W(3), .CNT_W(64), .PULSE_W(PW)) u_wdt_keyed (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_o(sys_rst_o)
  );

  // behavioural reference
  int          m_state;
  bit          m_en, m_svc, m_rst;
  int          m_left;
  logic [1:0]  m_mode;
  logic [63:0] m_cnt, m_prd;
  logic [31:0] m_rd;
  bit          started = 0;
  int          checks = 0, failures = 0;
  string       cur_req = "R1";
  logic [2:0]  rd_addr = 3'd5;
  bit          done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_en = 0; m_svc = 0; m_rst = 0; m_left = 0;
      m_mode = 0; m_cnt = 0; m_prd = 0; m_rd = 0;
    end else begin
      bit ctlw, fire, act;
      logic [15:0] k;
      logic [31:0] rd;
      act  = (m_state == 2);
      k    = bus_wdata[31:16];
      ctlw = bus_we && bus_addr == 3'd5 && m_mode == 2'b10;
      fire = act && ((m_cnt == m_prd) || (ctlw && k != 16'hA5C6 && k != 16'hDA7E));
      case (bus_addr)
        3'd0: rd = {30'd0, m_mode};
        3'd1: rd = m_cnt[31:0];
        3'd2: rd = m_cnt[63:32];
        3'd3: rd = m_prd[31:0];
        3'd4: rd = m_prd[63:32];
        3'd5: rd = (m_en ? 32'h4000 : 0) | (m_svc ? 32'h2000 : 0) | m_state;
        default: rd = 0;
      endcase
      m_rd = rd;
      if (fire) begin m_rst = 1; m_left = PW - 1; end
      else if (m_left > 0) m_left--;
      else m_rst = 0;
      if (bus_we && bus_addr == 3'd0 && !m_en) m_mode = bus_wdata[1:0];
      if (fire) begin
        m_state = 0; m_svc = 0; m_cnt = 0;
        if (ctlw && bus_wdata[14]) m_en = 1;
      end else begin
        if (act) begin
          if (ctlw && k == 16'hDA7E && m_svc) m_cnt = 0;
          else m_cnt = m_cnt + 1;
        end else if (bus_we) begin
          if (bus_addr == 3'd1) m_cnt[31:0]  = bus_wdata;
          if (bus_addr == 3'd2) m_cnt[63:32] = bus_wdata;
          if (bus_addr == 3'd3) m_prd[31:0]  = bus_wdata;
          if (bus_addr == 3'd4) m_prd[63:32] = bus_wdata;
        end
        if (ctlw) begin
          if (bus_wdata[14]) m_en = 1;
          if (m_state == 0 && k == 16'hA5C6 && m_en) m_state = 1;
          else if (m_state == 1 && k == 16'hDA7E) begin m_state = 2; m_svc = 0; end
          else if (m_state == 2 && k == 16'hA5C6) m_svc = 1;
          else if (m_state == 2 && k == 16'hDA7E) m_svc = 0;
        end
      end
      started = 1;
    end
  end

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      checks++;
      if (sys_rst_o !== m_rst) begin
        failures++;
        $display("FAIL %s sys_rst_o actual=%0b expected=%0b t=%0t", cur_req, sys_rst_o, m_rst, $time);
      end
      checks++;
      if (bus_rdata !== m_rd) begin
        failures++;
        $display("FAIL %s bus_rdata actual=%h expected=%h t=%0t", cur_req, bus_rdata, m_rd, $time);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = rd_addr; bus_wdata = 32'd0;
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    rd_addr = a;
    @(negedge clk);
    bus_addr = a;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input logic [15:0] key, input bit en);
    return {key, 1'b0, en, 14'd0};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    cur_req = "R1";
    for (int a = 0; a < 7; a++) idle(2, 3'(a));
    cur_req = "R3";  wr(3'd5, ctl(16'hA5C6, 1)); idle(3, 3'd5);
    cur_req = "R2";
    wr(3'd0, 32'h2); wr(3'd1, 32'h12345678); wr(3'd2, 32'hABCD0001);
    wr(3'd3, 32'd25); wr(3'd4, 32'h0);
    for (int a = 0; a < 8; a++) idle(2, 3'(a));
    wr(3'd1, 32'd0); wr(3'd2, 32'd0);
    cur_req = "R5";  wr(3'd5, ctl(16'hA5C6, 0)); idle(2, 3'd5);
    cur_req = "R7";  wr(3'd5, ctl(16'h1234, 0)); wr(3'd5, ctl(16'hDA7E, 0)); idle(2, 3'd5);
    cur_req = "R4";  wr(3'd5, ctl(16'h0000, 1)); idle(2, 3'd5);
    cur_req = "R5";  wr(3'd5, ctl(16'hA5C6, 0)); idle(2, 3'd5);
    cur_req = "R7";  wr(3'd5, ctl(16'hBEEF, 1)); wr(3'd5, ctl(16'hA5C6, 1)); idle(2, 3'd5);
    cur_req = "R6";  wr(3'd5, ctl(16'hDA7E, 1)); idle(5, 3'd1);
    cur_req = "R3";  wr(3'd0, 32'h0); idle(1, 3'd0);
    cur_req = "R4";  wr(3'd5, ctl(16'hA5C6, 0)); idle(1, 3'd5);
    cur_req = "R8";  wr(3'd5, ctl(16'hDA7E, 0)); idle(3, 3'd1);
    cur_req = "R12"; wr(3'd3, 32'd3); wr(3'd1, 32'd99); idle(2, 3'd3);
    cur_req = "R8";
    for (int s = 0; s < 3; s++) begin
      wr(3'd5, ctl(16'hA5C6, 1)); idle(1, 3'd5);
      wr(3'd5, ctl(16'hDA7E, 1)); idle(6, 3'd1);
    end
    wr(3'd5, ctl(16'hDA7E, 1)); idle(3, 3'd1);
    cur_req = "R10"; idle(30, 3'd5);
    cur_req = "R11"; idle(4, 3'd1); idle(3, 3'd5);
    cur_req = "R7";  wr(3'd5, ctl(16'hDA7E, 0)); idle(2, 3'd5);
    cur_req = "R5";  wr(3'd5, ctl(16'hA5C6, 0));
    cur_req = "R6";  wr(3'd5, ctl(16'hDA7E, 0)); idle(3, 3'd1);
    cur_req = "R9";  wr(3'd5, ctl(16'h0001, 1)); idle(8, 3'd5);
    cur_req = "R11"; idle(3, 3'd1);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule